// File: doc/BRIEF.md
# Instruction Line Alignment Buffer

This block sits between a 128-bit instruction fetch path and instruction dispatch. Each fetch word carries four 32-bit slots. Instruction lines are one to four instructions long and are packed back to back in memory with no alignment, so a line may begin at any slot and may run across two fetch words. The buffer stores up to five fetch words in a circular slot store. Each cycle it finds the next complete line at the read pointer and presents it to dispatch, left-justified, with a slot-valid mask.

Fetch is held back through a ready output when there is less than one fetch word of free space. A flush, raised on a taken branch or an interrupt, empties the buffer in a single cycle. The flush carries the slot offset at which the new stream starts inside the first fetch word that follows it.

Top module: `insn_align_buf`

## Requirements
- R1: After reset `fetch_ready_o` is 1, `line_valid_o` is 0 and `line_mask_o` is 0.
- R2: Slot j of a fetch word is bits [32j+31:32j], and slot 0 comes first in program order. Output slot k is `line_data_o` bits [32k+31:32k].
- R3: Bit 31 of an instruction marks the last instruction of its line. An emitted line of length n has `line_mask_o` equal to (1<<n)-1, carries its instructions in slots 0..n-1, and has zeros in the unused slots. When `line_valid_o` is 0, the mask and the data are 0.
- R4: A line is emitted only when every slot up to and including its end-marked instruction is stored. A partial line is held until the rest of it arrives.
- R5: A line that spans two fetch words is emitted as one line, in program order.
- R6: If four stored slots at the read pointer contain no end marker, those four slots are emitted as one line with mask 4'b1111.
- R7: The store holds 5 fetch words (20 slots). `fetch_ready_o` is 1 exactly when at most 16 slots are occupied. A fetch word offered while `fetch_ready_o` is 0 is ignored.
- R8: While `flush_i` is 1, `line_valid_o` is 0 and any fetch word offered is discarded. In the next cycle the buffer is empty: `line_valid_o` is 0 and `fetch_ready_o` is 1.
- R9: The first fetch word accepted after a flush is stored starting at slot `flush_off_i` (0..3), as sampled with the flush. Its lower slots are dropped.
- R10: A line shown with `line_valid_o` high is consumed at that clock edge. At most one line is emitted per cycle, and no instruction is lost, repeated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the buffer (branch or interrupt) |
| flush_off_i | input | 2 | Start slot in the first fetch word after a flush |
| fetch_valid_i | input | 1 | Fetch word offered |
| fetch_data_i | input | 128 | Fetch word, four 32-bit slots |
| fetch_ready_o | output | 1 | Room for one more fetch word |
| line_valid_o | output | 1 | A complete line is presented |
| line_data_o | output | 128 | Line, left-justified into slots 0..3 |
| line_mask_o | output | 4 | Valid slots of the line, contiguous from slot 0 |

## Verification
The line output is built combinationally from the stored slots, the read pointer and the occupancy count. A wrong pointer or count therefore shows at the ports in the same cycle as a shifted, duplicated or missing instruction, or as a mask of the wrong length. A count that drifts from the true fill level shows as `fetch_ready_o` switching a cycle early or late when the buffer is near full. It also shows as a line withheld when it is complete, or emitted before all of its slots have arrived. A bad flush offset shows on the first line after the flush, which carries the wrong leading instruction.

// File: rtl/insn_align_pkg.sv
package insn_align_pkg;
  localparam int SLOT_W = 32;
  localparam int SLOTS  = 4;
  localparam int LEN_W  = $clog2(SLOTS + 1);
  localparam int OFF_W  = $clog2(SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [SLOTS-1:0][SLOT_W-1:0] word_t;
endpackage

// File: rtl/insn_align_store.sv
module insn_align_store
  import insn_align_pkg::*;
#(
  parameter int CAP = 20,
  localparam int PW = $clog2(CAP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] wr_ptr_i,
  input  word_t         wdata_i,
  input  logic [PW-1:0] rd_ptr_i,
  output word_t         rslots_o
);
  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = 32'(p) + k;
    if (s >= CAP) s = s - CAP;
    return s[PW-1:0];
  endfunction

  slot_t mem_q [CAP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < CAP; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int j = 0; j < SLOTS; j++) mem_q[wrap(wr_ptr_i, j)] <= wdata_i[j];
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_rd
    assign rslots_o[k] = mem_q[wrap(rd_ptr_i, k)];
  end
endmodule

// File: rtl/insn_align_scan.sv
module insn_align_scan
  import insn_align_pkg::*;
#(
  parameter int CW = 5
) (
  input  word_t            slots_i,
  input  logic [CW-1:0]    avail_i,
  output logic [LEN_W-1:0] len_o,
  output logic [SLOTS-1:0] mask_o,
  output word_t            data_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    len_o = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!found && (32'(avail_i) > k) && slots_i[k][SLOT_W-1]) begin
        found = 1'b1;
        len_o = LEN_W'(k + 1);
      end
    end
    // no end marker within a full window: cap the line at SLOTS
    if (!found && (32'(avail_i) >= SLOTS)) len_o = LEN_W'(SLOTS);
    for (int k = 0; k < SLOTS; k++) begin
      mask_o[k] = (32'(len_o) > k);
      data_o[k] = mask_o[k] ? slots_i[k] : '0;
    end
  end
endmodule

// File: rtl/insn_align_buf.sv
module insn_align_buf
  import insn_align_pkg::*;
#(
  parameter int WORDS = 5,
  localparam int CAP = WORDS * SLOTS,
  localparam int PW  = $clog2(CAP),
  localparam int CW  = $clog2(CAP + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [OFF_W-1:0]   flush_off_i,
  input  logic               fetch_valid_i,
  input  logic [127:0]       fetch_data_i,
  output logic               fetch_ready_o,
  output logic               line_valid_o,
  output logic [127:0]       line_data_o,
  output logic [SLOTS-1:0]   line_mask_o
);
  logic [PW-1:0]    rd_ptr_q, wr_ptr_q;
  logic [CW-1:0]    cnt_q, add_w;
  logic [OFF_W-1:0] skip_q;
  logic             wr_fire;
  logic [LEN_W-1:0] scan_len, pop_len;
  logic [SLOTS-1:0] scan_mask;
  word_t            rslots, scan_data;

  function automatic logic [PW-1:0] wrap(input logic [PW-1:0] p, input int unsigned k);
    int unsigned s;
    s = 32'(p) + k;
    if (s >= CAP) s = s - CAP;
    return s[PW-1:0];
  endfunction

  assign fetch_ready_o = (cnt_q <= CW'(CAP - SLOTS));
  assign wr_fire       = fetch_valid_i & fetch_ready_o & ~flush_i;
  assign add_w         = wr_fire ? CW'(SLOTS - 32'(skip_q)) : '0;

  insn_align_store #(.CAP(CAP)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_fire),
    .wr_ptr_i (wr_ptr_q),
    .wdata_i  (word_t'(fetch_data_i)),
    .rd_ptr_i (rd_ptr_q),
    .rslots_o (rslots)
  );

  insn_align_scan #(.CW(CW)) u_scan (
    .slots_i (rslots),
    .avail_i (cnt_q),
    .len_o   (scan_len),
    .mask_o  (scan_mask),
    .data_o  (scan_data)
  );

  assign line_valid_o = (scan_len != '0) & ~flush_i;
  assign pop_len      = line_valid_o ? scan_len : '0;
  assign line_mask_o  = line_valid_o ? scan_mask : '0;
  assign line_data_o  = line_valid_o ? 128'(scan_data) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      skip_q   <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= PW'(flush_off_i);
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      skip_q   <= flush_off_i;
    end else begin
      rd_ptr_q <= wrap(rd_ptr_q, 32'(pop_len));
      cnt_q    <= cnt_q + add_w - CW'(pop_len);
      if (wr_fire) begin
        wr_ptr_q <= wrap(wr_ptr_q, SLOTS);
        skip_q   <= '0;
      end
    end
  end
endmodule

// File: rtl/insn_align_buf_chk.sv
module insn_align_buf_chk #(
  parameter int CAP = 20,
  parameter int CW  = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          flush_i,
  input logic          fetch_ready_o,
  input logic          line_valid_o,
  input logic [3:0]    line_mask_o,
  input logic [CW-1:0] cnt_i
);
  // R3
  mask_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_valid_o |-> (line_mask_o == 4'h1 || line_mask_o == 4'h3 ||
                      line_mask_o == 4'h7 || line_mask_o == 4'hf));
  // R3
  mask_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !line_valid_o |-> line_mask_o == 4'h0);
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!line_valid_o && fetch_ready_o));
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(CAP));
  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_ready_o && !flush_i) |=> cnt_i <= $past(cnt_i));
endmodule

bind insn_align_buf insn_align_buf_chk #(.CAP(CAP), .CW(CW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .flush_i       (flush_i),
  .fetch_ready_o (fetch_ready_o),
  .line_valid_o  (line_valid_o),
  .line_mask_o   (line_mask_o),
  .cnt_i         (cnt_q)
);

// File: tb/insn_align_buf_test.sv
module insn_align_buf_test;
  localparam int CLK_P = 10;
  localparam int CAP   = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic [1:0]   flush_off_i = '0;
  logic         fetch_valid_i = 1'b0;
  logic [127:0] fetch_data_i = '0;
  logic         fetch_ready_o, line_valid_o;
  logic [127:0] line_data_o;
  logic [3:0]   line_mask_o;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] q[$];
  int skip = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  insn_align_buf uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i), .flush_off_i(flush_off_i),
    .fetch_valid_i(fetch_valid_i), .fetch_data_i(fetch_data_i),
    .fetch_ready_o(fetch_ready_o), .line_valid_o(line_valid_o),
    .line_data_o(line_data_o), .line_mask_o(line_mask_o)
  );

  function automatic int exp_len();
    for (int k = 0; k < 4 && k < q.size(); k++) if (q[k][31]) return k + 1;
    return (q.size() >= 4) ? 4 : 0;
  endfunction

  function automatic logic [31:0] rslot(bit last);
    return {last, 31'($urandom)};
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one cycle: drive at negedge, check, update model at posedge
  task automatic cyc(bit fv, logic [127:0] d, bit fl, logic [1:0] off, string tag);
    int n;
    bit ev, er;
    logic [3:0] em;
    logic [127:0] ed;
    @(negedge clk_i);
    fetch_valid_i = fv; fetch_data_i = d; flush_i = fl; flush_off_i = off;
    #1;
    n  = exp_len();
    ev = (n > 0) && !fl;
    er = (q.size() <= CAP - 4);
    em = '0; ed = '0;
    if (ev) for (int k = 0; k < n; k++) begin em[k] = 1'b1; ed[32*k +: 32] = q[k]; end
    checks++;
    if (line_valid_o !== ev || line_mask_o !== em || line_data_o !== ed || fetch_ready_o !== er) begin
      errors++;
      $display("FAIL %s: valid/mask/ready %b/%h/%b data %h, expected %b/%h/%b data %h",
               tag, line_valid_o, line_mask_o, fetch_ready_o, line_data_o, ev, em, er, ed);
    end
    @(posedge clk_i);
    if (fl) begin
      q.delete(); skip = int'(off);
    end else begin
      if (ev) for (int k = 0; k < n; k++) void'(q.pop_front());
      if (fv && er) begin
        for (int j = skip; j < 4; j++) q.push_back(d[32*j +: 32]);
        skip = 0;
      end
    end
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 2'd0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: cycles %0d, expected < 200000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [127:0] w;
    void'($urandom(32'h1a5e));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    // R1 reset state
    idle(1, "R1");

    // R2 R3: lines of 1,2,1 within one word
    w = {rslot(1), rslot(1), rslot(0), rslot(1)};
    cyc(1'b1, w, 1'b0, 2'd0, "R2");
    idle(4, "R3");

    // R6: four slots without end marker
    w = {rslot(0), rslot(0), rslot(0), rslot(0)};
    cyc(1'b1, w, 1'b0, 2'd0, "R6");
    idle(2, "R6");

    // R9 R4 R5: start at slot 2, partial line held, then completed across words
    cyc(1'b0, '0, 1'b1, 2'd2, "R8");
    w = {rslot(0), rslot(0), rslot(1), rslot(1)};
    cyc(1'b1, w, 1'b0, 2'd0, "R9");
    idle(2, "R4");
    w = {rslot(1), rslot(1), rslot(0), rslot(1)};
    cyc(1'b1, w, 1'b0, 2'd0, "R5");
    idle(4, "R5");

    // R7: single-slot lines fill the store
    for (int i = 0; i < 12; i++)
      cyc(1'b1, {rslot(1), rslot(1), rslot(1), rslot(1)}, 1'b0, 2'd0, "R7");
    idle(25, "R10");

    // R8: flush with data present and a word offered in the flush cycle
    cyc(1'b1, {rslot(0), rslot(1), rslot(0), rslot(0)}, 1'b0, 2'd0, "R8");
    cyc(1'b1, {rslot(1), rslot(1), rslot(1), rslot(1)}, 1'b1, 2'd1, "R8");
    idle(2, "R8");
    cyc(1'b1, {rslot(1), rslot(0), rslot(1), rslot(1)}, 1'b0, 2'd0, "R9");
    idle(4, "R9");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      for (int j = 0; j < 4; j++) w[32*j +: 32] = rslot(($urandom % 3) == 0);
      cyc(($urandom % 4) != 0, w, ($urandom % 60) == 0, 2'($urandom), "R10");
    end
    idle(30, "R10");
    finish_run();
  end
endmodule